// File: doc/BRIEF.md
# Power-of-Two Clock Generator Divider

This block produces one divided clock from a small set of slow source clocks. A configuration word picks the source, turns the generator on or off, and sets a divide factor. The factor is read either as a plain integer or as an exponent, in which case the division is two raised to one more than the field value. A duty option gives equal high and low times for odd plain ratios. Without it, the high phase of an odd ratio is one source cycle shorter than the low phase.

All logic runs on a fast system clock. Each source is synchronised and its rising and falling edges are detected, so the generator can act on both edges of the selected source. A configuration write first lands in a pending holding register and raises a busy flag. The generator adopts the pending settings only at a safe point: at the end of the output period in progress, or at the next rising edge of the requested source while the generator is stopped. Busy drops once the settings are live. When the source changes, the generator finishes its period, parks low, and restarts on the new source.

Top module: `clkgen_pow2_div`

## Requirements
- R1: After reset, gen_clk_o and busy_o are low and the generator is disabled.
- R2: The configuration word layout is: bit 0 is enable, bit 1 is exponent mode, bit 2 is duty correction, bits 4:3 are the source select, and bits 8:5 are DIV. A cycle with cfg_wr_i high captures the word, and busy_o is high from the next cycle.
- R3: busy_o stays high until the pending settings take effect and drops in the cycle after that. A second write before then replaces the first, and only the last word takes effect.
- R4: While the active settings have enable low, gen_clk_o stays low.
- R5: With exponent mode clear, the output period is N source cycles, where N is DIV. DIV values 0 and 1 both give N = 1.
- R6: With exponent mode set, N = 2^(DIV+1). For example, DIV = 4 gives N = 32.
- R7: With duty correction clear, the high phase lasts as follows. For even N it is N/2 source cycles. For odd N above 1 it is (N-1)/2 source cycles, and the low phase is (N+1)/2. For N = 1 it is half a source cycle.
- R8: With duty correction set, the high and low phases are each N source half-cycles long.
- R9: Clearing enable while running lets the current output period finish. The output then stays low. busy_o is still high during the final low phase.
- R10: The output is built from the selected source. A source change while running completes the current period on the old source, holds the output low, and starts a fresh period on the new source.
- R11: A ratio change while running takes effect at the period boundary. The period in progress keeps the old ratio.
- R12: While stopped, pending settings take effect on the next rising edge of their selected source. If enabled, output starts high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_clk_i | input | NUM_SRC | Candidate source clocks |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 9 | Configuration word (layout in R2) |
| gen_clk_o | output | 1 | Divided output clock |
| busy_o | output | 1 | Settings written but not yet in effect |

## Verification
The bench sweeps every plain DIV value and the low exponent values, with and without duty correction. It measures each high and low phase in system cycles against the ratio worked out arithmetically. A design that swapped the rounding of odd ratios or mishandled DIV of 0 or 1 would show one phase short by a source cycle or a period of zero. The bench also rewrites the settings mid-period: changing the ratio, disabling the generator, and switching the source. A design that applied settings immediately would truncate the period in progress or drop busy too early. A source switch without the park-low step would show a high phase cut short on the old source.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Field widths of the configuration word and the derived sizes.
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned DIV_W    = 4;
  localparam int unsigned SRC_SPAN = 1 << SEL_W;
  localparam int unsigned CFG_W    = 3 + SEL_W + DIV_W;
  // Half-cycle counter must hold 2 * 2^(2^DIV_W).
  localparam int unsigned CNT_W    = (1 << DIV_W) + 2;

  // Packed MSB first, so en lands on bit 0 of the word.
  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] sel;
    logic             duty;
    logic             expo;
    logic             en;
  } cfg_t;

  // Division factor N in source cycles.
  function automatic logic [CNT_W-1:0] ratio_of(cfg_t c);
    logic [CNT_W-1:0] one;
    logic [DIV_W:0]   sh;
    one = CNT_W'(1);
    sh  = {1'b0, c.div} + 1'b1;
    if (c.expo)              return one << sh;
    else if (c.div < 2)      return one;
    else                     return CNT_W'(c.div);
  endfunction

  // Length of the high phase, counted in source half-cycles.
  function automatic logic [CNT_W-1:0] high_halves(cfg_t c);
    logic [CNT_W-1:0] n;
    n = ratio_of(c);
    if (n == CNT_W'(1))          return CNT_W'(1);
    else if (c.duty || !n[0])    return n;
    else                         return n - CNT_W'(1);
  endfunction

endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/clkgen_src_edges.sv
module clkgen_src_edges
  import clkgen_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic [SRC_SPAN-1:0] rise_o,
  output logic [SRC_SPAN-1:0] fall_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  for (genvar i = 0; i < SRC_SPAN; i++) begin : g_src
    if (i < NUM_SRC) begin : g_live
      // Synchroniser stages plus one history stage for edge detection.
      logic [LAST:0] chain_q;
      logic [LAST:0] chain_d;

      always_comb chain_d = {chain_q[LAST-1:0], src_i[i]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign rise_o[i] =  chain_q[LAST-1] & ~chain_q[LAST];
      assign fall_o[i] = ~chain_q[LAST-1] &  chain_q[LAST];
    end else begin : g_tie
      assign rise_o[i] = 1'b0;
      assign fall_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic             commit_i,
  output cfg_t             pend_o,
  output logic             valid_o
);
  cfg_t pend_q, pend_d;
  logic valid_q, valid_d;
  logic ce;

  always_comb begin
    pend_d  = pend_q;
    valid_d = valid_q;
    if (wr_i) begin
      // A fresh write always wins over a commit of the older word.
      pend_d  = cfg_t'(data_i);
      valid_d = 1'b1;
    end else if (commit_i) begin
      valid_d = 1'b0;
    end
    ce = wr_i | commit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
    end else if (ce) begin
      pend_q  <= pend_d;
      valid_q <= valid_d;
    end
  end

  assign pend_o  = pend_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/clkgen_div_core.sv
module clkgen_div_core
  import clkgen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_SPAN-1:0] rise_i,
  input  logic [SRC_SPAN-1:0] fall_i,
  input  logic                pend_valid_i,
  input  cfg_t                pend_i,
  output logic                commit_o,
  output logic                run_o,
  output logic                tick_o,
  output logic                out_o
);
  cfg_t             act_q, act_d;
  logic             run_q, run_d;
  logic             out_q, out_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             act_rise, act_edge, pend_rise;
  logic [CNT_W-1:0] n_act, total, hi;
  logic             last_half;
  logic             ce;

  always_comb begin
    act_rise  = rise_i[act_q.sel];
    act_edge  = act_rise | fall_i[act_q.sel];
    pend_rise = pend_valid_i & rise_i[pend_i.sel];
    n_act     = ratio_of(act_q);
    total     = {n_act[CNT_W-2:0], 1'b0};
    hi        = high_halves(act_q);
    last_half = (cnt_q == total - CNT_W'(1));

    act_d    = act_q;
    run_d    = run_q;
    out_d    = out_q;
    cnt_d    = cnt_q;
    commit_o = 1'b0;

    if (run_q) begin
      if (act_edge) begin
        if (last_half) begin
          // Period boundary: the only point where a running generator changes.
          cnt_d = '0;
          if (pend_valid_i) begin
            commit_o = 1'b1;
            act_d    = pend_i;
            if (pend_i.en && (pend_i.sel == act_q.sel)) begin
              out_d = 1'b1;
            end else begin
              run_d = 1'b0;
              out_d = 1'b0;
            end
          end else begin
            out_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
          out_d = (cnt_q + CNT_W'(1)) < hi;
        end
      end
    end else begin
      if (pend_rise) begin
        commit_o = 1'b1;
        act_d    = pend_i;
        cnt_d    = '0;
        run_d    = pend_i.en;
        out_d    = pend_i.en;
      end else if (act_q.en && act_rise) begin
        // Restart after a source change parked the output.
        cnt_d = '0;
        run_d = 1'b1;
        out_d = 1'b1;
      end
    end

    ce = act_edge | pend_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (ce) begin
      act_q <= act_d;
      run_q <= run_d;
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o  = run_q;
  assign tick_o = ce;
  assign out_o  = out_q;
endmodule

// File: rtl/clkgen_pow2_div.sv
module clkgen_pow2_div
  import clkgen_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_data_i,
  output logic               gen_clk_o,
  output logic               busy_o
);
  logic                rst_n_s;
  logic [SRC_SPAN-1:0] rise, fall;
  cfg_t                pend;
  logic                pend_valid;
  logic                commit;
  logic                run;
  logic                tick;

  clkgen_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  clkgen_src_edges #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edges (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .src_i  (src_clk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  clkgen_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_i     (cfg_wr_i),
    .data_i   (cfg_data_i),
    .commit_i (commit),
    .pend_o   (pend),
    .valid_o  (pend_valid)
  );

  clkgen_div_core u_core (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .rise_i       (rise),
    .fall_i       (fall),
    .pend_valid_i (pend_valid),
    .pend_i       (pend),
    .commit_o     (commit),
    .run_o        (run),
    .tick_o       (tick),
    .out_o        (gen_clk_o)
  );

  assign busy_o = pend_valid;
endmodule

// File: rtl/clkgen_pow2_div_chk.sv
module clkgen_pow2_div_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic busy,
  input logic commit,
  input logic run,
  input logic tick,
  input logic gen_clk
);
  p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> busy);

  p_commit_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !gen_clk);

  p_paced_by_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_clk != $past(gen_clk)) |-> $past(tick));
endmodule

bind clkgen_pow2_div clkgen_pow2_div_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .cfg_wr  (cfg_wr_i),
  .busy    (busy_o),
  .commit  (commit),
  .run     (run),
  .tick    (tick),
  .gen_clk (gen_clk_o)
);

// File: tb/clkgen_pow2_div_bench.sv
`timescale 1ns/1ps
module clkgen_pow2_div_bench;
  import clkgen_pkg::*;

  localparam int NS = 4;
  localparam int HALF [NS] = '{2, 3, 5, 4};  // source half periods in clk cycles

  logic             clk;
  logic             rst_n;
  logic [NS-1:0]    src;
  logic             cfg_wr;
  logic [CFG_W-1:0] cfg_data;
  logic             gen_clk;
  logic             busy;

  int nchecks = 0;
  int nerrors = 0;
  int hi, lo;

  clkgen_pow2_div u_clkgen_pow2_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_clk_i  (src),
    .cfg_wr_i   (cfg_wr),
    .cfg_data_i (cfg_data),
    .gen_clk_o  (gen_clk),
    .busy_o     (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  for (genvar k = 0; k < NS; k++) begin : g_src
    logic s;
    initial begin
      s = 1'b0;
      #3;
      forever #(HALF[k] * 10) s = ~s;
    end
    assign src[k] = s;
  end

  task automatic chk(input string req, input int got, input int exp);
    nchecks++;
    if (got != exp) begin
      nerrors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  function automatic int ratio(input bit ex, input int div);
    if (ex) return 1 << (div + 1);
    return (div < 2) ? 1 : div;
  endfunction

  function automatic int hi_halves(input bit ex, input bit du, input int div);
    int n;
    n = ratio(ex, div);
    if (n == 1) return 1;
    if (du || (n % 2 == 0)) return n;
    return n - 1;
  endfunction

  task automatic wr(input bit en, input bit ex, input bit du, input int sel, input int div);
    @(negedge clk);
    cfg_wr   = 1'b1;
    cfg_data = {DIV_W'(div), SEL_W'(sel), du, ex, en};
    @(negedge clk);
    cfg_wr   = 1'b0;
    chk("R2 busy after write", int'(busy), 1);
  endtask

  task automatic wait_not_busy();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_rise();
    bit p;
    do begin
      p = gen_clk;
      @(negedge clk);
    end while (!(p == 1'b0 && gen_clk == 1'b1));
  endtask

  // Starts on a high sample, ends on the next rising sample.
  task automatic meas(output int h, output int l);
    h = 0;
    while (gen_clk) begin h++; @(negedge clk); end
    l = 0;
    while (!gen_clk) begin l++; @(negedge clk); end
  endtask

  task automatic run_case(input bit ex, input bit du, input int sel, input int div);
    int n, hh;
    wr(1'b1, ex, du, sel, div);
    wait_not_busy();
    wait_rise();
    meas(hi, lo);
    n  = ratio(ex, div);
    hh = hi_halves(ex, du, div);
    chk(ex ? "R6 period" : "R5 period", hi + lo, 2 * n * HALF[sel]);
    chk(du ? "R8 high" : "R7 high", hi, hh * HALF[sel]);
    chk(du ? "R8 low" : "R7 low", lo, (2 * n - hh) * HALF[sel]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerrors++;
    nchecks++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

  initial begin
    int cnt;
    rst_n    = 1'b0;
    cfg_wr   = 1'b0;
    cfg_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R4 quiet while disabled
    chk("R1 out", int'(gen_clk), 0);
    chk("R1 busy", int'(busy), 0);
    cnt = 0;
    repeat (50) begin @(negedge clk); if (gen_clk) cnt++; end
    chk("R1 no toggle", cnt, 0);

    // R4 disabled config committed, output silent
    wr(1'b0, 1'b0, 1'b0, 0, 2);
    wait_not_busy();
    cnt = 0;
    repeat (200) begin @(negedge clk); if (gen_clk) cnt++; end
    chk("R4 disabled low", cnt, 0);

    // R12 commit while stopped on next rising edge of source 2
    wr(1'b1, 1'b0, 1'b0, 2, 2);
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R12 prompt commit", int'(cnt <= 2 * HALF[2] + 6), 1);
    wait_rise();
    meas(hi, lo);
    chk("R12 high", hi, 2 * HALF[2]);
    chk("R12 low", lo, 2 * HALF[2]);

    // R5 R7 R8 plain ratio sweep on source 0
    for (int d = 0; d < 16; d++) begin
      for (int du = 0; du < 2; du++) run_case(1'b0, du[0], 0, d);
    end

    // R6 exponent sweep on source 1, DIV 4 gives 32
    for (int d = 0; d < 5; d++) begin
      for (int du = 0; du < 2; du++) run_case(1'b1, du[0], 1, d);
    end

    // R10 other sources
    run_case(1'b0, 1'b0, 3, 3);
    run_case(1'b0, 1'b0, 2, 4);

    // R10 switch source mid-period: old period completes, then restart
    wait_rise();
    fork
      wr(1'b1, 1'b0, 1'b0, 3, 4);
      meas(hi, lo);
    join
    chk("R10 old high", hi, 4 * HALF[2]);
    chk("R10 parked low", int'(lo >= 4 * HALF[2]), 1);
    meas(hi, lo);
    chk("R10 new high", hi, 4 * HALF[3]);
    chk("R10 new low", lo, 4 * HALF[3]);

    // R11 ratio change at the period boundary
    run_case(1'b0, 1'b0, 0, 6);
    wait_rise();
    fork
      wr(1'b1, 1'b0, 1'b0, 0, 10);
      meas(hi, lo);
    join
    chk("R11 old high", hi, 6 * HALF[0]);
    chk("R11 old low", lo, 6 * HALF[0]);
    meas(hi, lo);
    chk("R11 new high", hi, 10 * HALF[0]);
    chk("R11 new low", lo, 10 * HALF[0]);

    // R3 second write replaces first
    fork
      begin
        wr(1'b1, 1'b0, 1'b0, 0, 9);
        wr(1'b1, 1'b0, 1'b0, 0, 5);
      end
      meas(hi, lo);
    join
    chk("R3 old period", hi + lo, 20 * HALF[0]);
    meas(hi, lo);
    chk("R3 last word high", hi, 4 * HALF[0]);
    chk("R3 last word low", lo, 6 * HALF[0]);
    chk("R3 busy cleared", int'(busy), 0);

    // R9 disable finishes current period then stays low
    run_case(1'b0, 1'b0, 0, 8);
    wait_rise();
    fork
      wr(1'b0, 1'b0, 1'b0, 0, 8);
      begin
        hi = 0;
        while (gen_clk) begin hi++; @(negedge clk); end
      end
    join
    chk("R9 full high", hi, 8 * HALF[0]);
    chk("R9 busy in last low", int'(busy), 1);
    cnt = 0;
    while (!gen_clk && cnt < 300) begin cnt++; @(negedge clk); end
    chk("R9 stays low", cnt, 300);
    chk("R9 busy cleared", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end
endmodule